// File: doc/BRIEF.md
# Charge Status Pin Duty-Cycle Decoder

This block sits on the host side of a charger status line. The line is open-drain with a pull-up. The block samples the line with a fast system clock and sorts it into one of four conditions: charging, not charging, temperature fault or bad battery.

A steady low means a charge is in progress, and a steady high means the charger has released the line. A fault is signalled by a carrier of roughly 35 kHz. The carrier's duty alternates slowly between a small value and its complement, so that a lamp on the line appears to blink. The decoder does not track the blink. It measures every single carrier cycle and accepts either member of a complementary pair as the same fault.

The line first passes through a two-flop synchroniser. The block then counts the high time and the full period between consecutive rising edges and compares the duty against tolerance windows. When no edge of either polarity arrives within a parameterised number of carrier periods, it makes a steady-level evaluation instead. When a reading lands on the dim/bright crossover, the duty comes out at exactly one half. Such a reading is thrown away and the next cycle is measured. The reported class moves only after consecutive evaluations agree. A one-cycle strobe marks each newly reported known class.

Top module: `chg_status_decoder`

## Requirements
- R1: After reset, `clsOut` is 0 (unknown) and `clsValid` is 0.
- R2: With the line held low and no edge for two consecutive windows of `TIMEOUT_PERIODS*CARRIER_CYC` clocks, `clsOut` becomes 1 (charging).
- R3: With the line held high and no edge for two such windows, `clsOut` becomes 2 (not charging).
- R4: A carrier whose high time over period lies within ±`TOL128`/128 of 6.25% or of 93.75% reports code 3 (temperature fault).
- R5: A carrier whose duty lies within ±`TOL128`/128 of 12.5% or of 87.5% reports code 4 (bad battery).
- R6: A measured cycle where twice the high time equals the period exactly is discarded. It changes neither the reported class nor the agreement count.
- R7: A carrier duty outside every window reports code 0 (unknown), and `clsValid` stays low.
- R8: The reported class changes only after `AGREE` (default 2) consecutive evaluations agree. A single differing evaluation between agreeing ones has no effect.
- R9: `clsValid` pulses for one clock exactly when `clsOut` changes to a known code (1 to 4). It never pulses otherwise.
- R10: A fault that alternates between its two complementary duties keeps its code and raises no further strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous |
| statusPin | input | 1 | Asynchronous pulled-up status line |
| clsOut | output | 3 | Reported class: 0 unknown, 1 charging, 2 not charging, 3 temperature, 4 bad battery |
| clsValid | output | 1 | One-clock strobe for a newly reported known class |

## Verification
Every high time from 1 to 31 clocks is swept on a 32-clock carrier, starting from a confirmed charging state each time. This sweep separates the four fault duties, the exact-half reading and every off-window duty that must give unknown. Long steady-low and steady-high holds exercise the timeout path. A blink pattern that alternates 6.25% and 93.75% checks that the complementary duties are treated as one fault. Two sequences check the agreement rule: one places a lone bad-battery cycle inside a temperature fault, and the other places an exact-half cycle between two agreeing cycles. Together they tell a correct agreement rule from one that counts the discarded reading or promotes too early.

// File: rtl/chg_status_pkg.sv
package chg_status_pkg;

  typedef enum logic [2:0] {
    CLS_UNKNOWN  = 3'd0,
    CLS_CHARGING = 3'd1,
    CLS_IDLE     = 3'd2,
    CLS_TEMP     = 3'd3,
    CLS_BADBAT   = 3'd4
  } statusCls_e;

  // Strobes and result handed from the datapath to the control
  typedef struct packed {
    logic       measDone;
    logic       steadyDone;
    logic       exact50;
    statusCls_e cls;
  } dpEvt_t;

  localparam int NUM_WINDOWS = 4;

  // Nominal duty of each window in 1/128 units
  function automatic int windowNom128(int idx);
    case (idx)
      0:       return 8;
      1:       return 120;
      2:       return 16;
      default: return 112;
    endcase
  endfunction

  function automatic statusCls_e windowCls(int idx);
    return (idx < 2) ? CLS_TEMP : CLS_BADBAT;
  endfunction

endpackage

// File: rtl/chg_status_dp.sv
module chg_status_dp
  import chg_status_pkg::*;
#(
  parameter int CARRIER_CYC     = 1429,
  parameter int TIMEOUT_PERIODS = 4,
  parameter int TOL128          = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   statusPin,
  output dpEvt_t evt
);

  localparam int TIMEOUT_CYC = CARRIER_CYC * TIMEOUT_PERIODS;
  localparam int CW          = $clog2(2 * TIMEOUT_CYC + 2);
  localparam int PW          = CW + 8;
  localparam logic [CW-1:0] CNT_MAX   = '1;
  localparam logic [CW-1:0] IDLE_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] TOL_W     = PW'(TOL128);

  logic pinMeta, pinSync, pinPrev;
  logic rise, anyEdge, steadyHit, haveEdge;
  logic [CW-1:0] periodCnt, highCnt, idleCnt;
  logic [PW-1:0] pWide, hScaled;
  logic [NUM_WINDOWS-1:0] hit;
  statusCls_e matchCls, steadyCls;

  // Two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinMeta <= 1'b0;
      pinSync <= 1'b0;
      pinPrev <= 1'b0;
    end else begin
      pinMeta <= statusPin;
      pinSync <= pinMeta;
      pinPrev <= pinSync;
    end
  end

  assign rise      = pinSync & ~pinPrev;
  assign anyEdge   = pinSync ^ pinPrev;
  assign steadyHit = !anyEdge && (idleCnt == IDLE_LAST);
  assign steadyCls = pinSync ? CLS_IDLE : CLS_CHARGING;

  // Period and high-time counters, restarted on every rising edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      highCnt   <= '0;
    end else if (rise) begin
      periodCnt <= CW'(1);
      highCnt   <= CW'(1);
    end else begin
      if (periodCnt != CNT_MAX) periodCnt <= periodCnt + CW'(1);
      if (pinSync && highCnt != CNT_MAX) highCnt <= highCnt + CW'(1);
    end
  end

  // Edge-free interval counter; a full window yields a steady evaluation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= '0;
      haveEdge <= 1'b0;
    end else begin
      if (anyEdge || steadyHit) idleCnt <= '0;
      else                      idleCnt <= idleCnt + CW'(1);
      if (steadyHit)  haveEdge <= 1'b0;
      else if (rise)  haveEdge <= 1'b1;
    end
  end

  assign pWide   = PW'(periodCnt);
  assign hScaled = PW'(highCnt) << 7;

  // One tolerance comparator per nominal duty
  for (genvar g = 0; g < NUM_WINDOWS; g++) begin : gWin
    localparam logic [PW-1:0] NOM = PW'(windowNom128(g));
    logic [PW-1:0] target, span, diff;
    always_comb begin
      target = pWide * NOM;
      span   = pWide * TOL_W;
      diff   = (hScaled >= target) ? hScaled - target : target - hScaled;
    end
    assign hit[g] = (diff <= span);
  end

  always_comb begin
    matchCls = CLS_UNKNOWN;
    for (int i = NUM_WINDOWS - 1; i >= 0; i--) begin
      if (hit[i]) matchCls = windowCls(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evt <= '{measDone: 1'b0, steadyDone: 1'b0, exact50: 1'b0, cls: CLS_UNKNOWN};
    end else begin
      evt.measDone   <= rise && haveEdge;
      evt.steadyDone <= steadyHit;
      evt.exact50    <= ((PW'(highCnt) << 1) == pWide);
      evt.cls        <= steadyHit ? steadyCls : matchCls;
    end
  end

  // R4
  meas_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.measDone |=> !evt.measDone);

  // R2
  steady_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.steadyDone |=> !evt.steadyDone);

  // R2
  steady_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.steadyDone && evt.measDone));

endmodule

// File: rtl/chg_status_ctrl.sv
module chg_status_ctrl
  import chg_status_pkg::*;
#(
  parameter int AGREE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpEvt_t     evt,
  output statusCls_e clsOut,
  output logic       clsValid
);

  localparam int AW = $clog2(AGREE + 1);
  localparam logic [AW-1:0] AGREE_C = AW'(AGREE);

  logic evtUse, promote;
  statusCls_e cand, candNext;
  logic [AW-1:0] cnt, cntNext;

  always_comb begin
    evtUse   = evt.steadyDone || (evt.measDone && !evt.exact50);
    candNext = cand;
    cntNext  = cnt;
    if (evtUse) begin
      if (evt.cls == cand) begin
        cntNext = (cnt == AGREE_C) ? cnt : cnt + AW'(1);
      end else begin
        candNext = evt.cls;
        cntNext  = AW'(1);
      end
    end
    promote = evtUse && (cntNext == AGREE_C) && (candNext != clsOut);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand     <= CLS_UNKNOWN;
      cnt      <= '0;
      clsOut   <= CLS_UNKNOWN;
      clsValid <= 1'b0;
    end else begin
      cand     <= candNext;
      cnt      <= cntNext;
      clsValid <= promote && (candNext != CLS_UNKNOWN);
      if (promote) clsOut <= candNext;
    end
  end

  // R9
  valid_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    clsValid |-> clsOut != CLS_UNKNOWN);

  // R9
  valid_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clsOut != $past(clsOut) && clsOut != CLS_UNKNOWN) |-> clsValid);

  // R6
  half_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evt.measDone && evt.exact50) |=> (clsOut == $past(clsOut) && !clsValid));

  // R8
  agree_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= AGREE_C);

  // R8
  change_needs_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clsOut != $past(clsOut)) |-> $past(evtUse));

endmodule

// File: rtl/chg_status_decoder.sv
module chg_status_decoder
  import chg_status_pkg::*;
#(
  parameter int CARRIER_CYC     = 1429,
  parameter int TIMEOUT_PERIODS = 4,
  parameter int TOL128          = 3,
  parameter int AGREE           = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       statusPin,
  output logic [2:0] clsOut,
  output logic       clsValid
);

  dpEvt_t     evt;
  statusCls_e clsEnum;

  chg_status_dp #(
    .CARRIER_CYC    (CARRIER_CYC),
    .TIMEOUT_PERIODS(TIMEOUT_PERIODS),
    .TOL128         (TOL128)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .statusPin(statusPin),
    .evt      (evt)
  );

  chg_status_ctrl #(
    .AGREE(AGREE)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .clsOut  (clsEnum),
    .clsValid(clsValid)
  );

  assign clsOut = clsEnum;

endmodule

// File: tb/test_chg_status_decoder.sv
module test_chg_status_decoder;

  localparam int PER = 32;
  localparam int TOL = 3;

  logic clk = 1'b0;
  logic rstN;
  logic pin;
  logic [2:0] cls;
  logic vld;
  int total = 0;
  int bad = 0;
  int vldCount = 0;

  always #10 clk = ~clk;

  chg_status_decoder #(
    .CARRIER_CYC(PER), .TIMEOUT_PERIODS(4), .TOL128(TOL), .AGREE(2)
  ) i_chg_status_decoder (
    .clk(clk), .rstN(rstN), .statusPin(pin), .clsOut(cls), .clsValid(vld)
  );

  always @(posedge clk) if (rstN && vld) vldCount++;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic holdLevel(logic lvl, int cyc);
    pin = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic drivePeriods(int h, int n);
    for (int k = 0; k < n; k++) begin
      pin = 1'b1;
      repeat (h) @(negedge clk);
      pin = 1'b0;
      repeat (PER - h) @(negedge clk);
    end
  endtask

  function automatic int expCls(int h);
    int noms[4] = '{8, 120, 16, 112};
    for (int i = 0; i < 4; i++) begin
      int d = h * 128 - PER * noms[i];
      if (d < 0) d = -d;
      if (d <= PER * TOL) return (i < 2) ? 3 : 4;
    end
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0;
    int e;
    rstN = 1'b0;
    pin  = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 cls", int'(cls), 0);
    check("R1 valid", int'(vld), 0);
    rstN = 1'b1;

    holdLevel(1'b1, 300);
    check("R3 steady high", int'(cls), 2);
    check("R9 strobe count", vldCount, 1);

    holdLevel(1'b0, 300);
    check("R2 steady low", int'(cls), 1);

    // Sweep of every high time on the small carrier
    for (int h = 1; h < PER; h++) begin
      holdLevel(1'b0, 300);
      check("R2 re-arm", int'(cls), 1);
      v0 = vldCount;
      drivePeriods(h, 4);
      holdLevel(1'b0, 6);
      if (h * 2 == PER) begin
        check("R6 half ignored", int'(cls), 1);
        check("R6 no strobe", vldCount - v0, 0);
      end else begin
        e = expCls(h);
        if (e == 3)      check("R4 temp", int'(cls), 3);
        else if (e == 4) check("R5 badbat", int'(cls), 4);
        else             check("R7 unknown", int'(cls), 0);
        if (e == 0) check("R7 no strobe", vldCount - v0, 0);
        else        check("R9 one strobe", vldCount - v0, 1);
      end
    end

    // Blink between complementary temperature duties
    holdLevel(1'b0, 300);
    v0 = vldCount;
    drivePeriods(2, 3);
    for (int k = 0; k < 3; k++) begin
      drivePeriods(30, 2);
      drivePeriods(2, 2);
    end
    check("R10 blink class", int'(cls), 3);
    check("R10 blink strobes", vldCount - v0, 1);

    // Lone bad-battery cycle inside a temperature fault
    v0 = vldCount;
    drivePeriods(2, 1);
    drivePeriods(4, 1);
    drivePeriods(2, 2);
    holdLevel(1'b0, 6);
    check("R8 outlier class", int'(cls), 3);
    check("R8 outlier strobes", vldCount - v0, 0);

    // Exact half between two agreeing cycles
    holdLevel(1'b0, 300);
    v0 = vldCount;
    drivePeriods(4, 1);
    drivePeriods(16, 1);
    drivePeriods(4, 2);
    holdLevel(1'b0, 6);
    check("R6 half skipped", int'(cls), 4);
    check("R9 half strobe", vldCount - v0, 1);

    // A single measurement is not enough
    holdLevel(1'b0, 300);
    v0 = vldCount;
    drivePeriods(2, 2);
    holdLevel(1'b0, 6);
    check("R8 single eval", int'(cls), 1);
    check("R8 single strobe", vldCount - v0, 0);

    holdLevel(1'b1, 300);
    check("R3 release", int'(cls), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule